// File: doc/BRIEF.md
# Transmit Oversize-Frame and Collision-Heartbeat Monitor

This block sits beside a transmit path and raises two error pulses. It counts the payload bytes of each outgoing frame, which excludes the preamble and the start-of-frame delimiter. A babble pulse fires when the count passes the largest legal frame length. The frame is not cut short: transmission simply carries on until the frame ends or is aborted.

The block also checks that the transceiver's collision line toggles as a heartbeat. The line may be seen at any point while the frame is being sent, or within a fixed 4 µs window after the frame ends. If it is not seen by either route, a heartbeat-failure pulse is raised. The window is timed in clock cycles derived from a cycles-per-microsecond parameter.

Both outputs are single-cycle pulses, meant to set sticky flags in a status register elsewhere.

Top module: `txm_monitor`

## Requirements
- R1: After reset both `babble_pulse` and `hb_fail_pulse` are low and no check is pending.
- R2: `babble_pulse` is high for the one cycle that follows the clock edge at which the 1519th `byte_vld` of a frame is sampled. Bytes are counted from the last `frm_start`.
- R3: A frame of exactly 1518 valid bytes raises no `babble_pulse`.
- R4: `babble_pulse` fires at most once per frame, however many bytes follow. A later frame can fire it again.
- R5: `byte_vld` strobes sampled after `frm_end` or `frm_abort` and before the next `frm_start` are ignored. They do not push the count toward babble.
- R6: If `coll_in` is sampled high in any cycle from `frm_start` to `frm_end` inclusive, the frame raises no `hb_fail_pulse`.
- R7: The window is W = 4·CYC_PER_US cycles after the `frm_end` edge. If `coll_in` is sampled high in any of those W cycles, there is no failure. Otherwise `hb_fail_pulse` is high in the cycle after the W-th edge following `frm_end`.
- R8: A collision in the last (W-th) window cycle still passes. With no collision at all, the failure pulse appears exactly at the window's end and not earlier.
- R9: A `frm_start` while a window is open, with no collision seen so far, resolves the pending check as failed. `hb_fail_pulse` is high in the next cycle.
- R10: `frm_abort` cancels the heartbeat check of the current frame, so no `hb_fail_pulse` results from it.
- R11: Each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Strobe: a frame begins |
| frm_end | input | 1 | Strobe: the frame completed normally |
| frm_abort | input | 1 | Strobe: the frame was abandoned |
| byte_vld | input | 1 | One payload byte (after the start delimiter) sent this cycle |
| coll_in | input | 1 | Collision input from the transceiver |
| babble_pulse | output | 1 | Oversize-frame error pulse |
| hb_fail_pulse | output | 1 | Heartbeat-failure error pulse |

## Verification
Directed frames of 1518, 1519 and about 1600 bytes separate the exact length threshold from the once-per-frame rule. Stray bytes after a 1518-byte frame show whether bytes outside a frame are wrongly counted. For the heartbeat, collisions are placed in four positions: inside the frame, at the first window cycle, at the last window cycle, and one cycle past the window. These pin down the window's edges. Random frames near the length limit, with random collision placement and occasional aborts, are compared against bench functions that predict each pulse count.

// File: rtl/txm_pkg.sv
package txm_pkg;
  typedef enum logic [1:0] {
    HB_IDLE = 2'd0,
    HB_TX   = 2'd1,
    HB_WAIT = 2'd2
  } hb_state_e;
endpackage

// File: rtl/txm_len_guard.sv
module txm_len_guard #(
  parameter int unsigned LIMIT = 1519
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic frm_stop,
  input  logic byte_vld,
  output logic babble_pulse
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic act_q, act_d;
  logic fired_q, fired_d;
  logic pulse_q, pulse_d;
  logic cnt_en;

  always_comb begin
    cnt_d   = cnt_q;
    act_d   = act_q;
    fired_d = fired_q;
    pulse_d = 1'b0;
    cnt_en  = act_q && byte_vld && (cnt_q != TOP);
    if (frm_start) begin
      cnt_d   = '0;
      act_d   = 1'b1;
      fired_d = 1'b0;
    end else begin
      if (cnt_en) cnt_d = cnt_q + 1'b1;
      if (act_q && byte_vld && !fired_q && (cnt_q == LAST)) begin
        fired_d = 1'b1;
        pulse_d = 1'b1;
      end
      if (frm_stop) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      fired_q <= fired_d;
      pulse_q <= pulse_d;
    end
  end

  assign babble_pulse = pulse_q;

  assert_babble_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    babble_pulse |=> !babble_pulse);
  assert_babble_on_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    babble_pulse |-> $past(byte_vld));
  assert_babble_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !frm_start) |=> !babble_pulse);
  assert_babble_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !frm_start) |=> !babble_pulse);
endmodule

// File: rtl/txm_sqe_watch.sv
module txm_sqe_watch
  import txm_pkg::*;
#(
  parameter int unsigned WIN = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic frm_end,
  input  logic frm_abort,
  input  logic coll_in,
  output logic hb_fail_pulse
);
  localparam int unsigned TW = $clog2(WIN + 1);
  localparam logic [TW-1:0] TLAST = TW'(WIN - 1);

  hb_state_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic seen_q, seen_d;
  logic fail_q, fail_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    seen_d  = seen_q;
    fail_d  = 1'b0;
    if (frm_abort) begin
      state_d = HB_IDLE;
      seen_d  = 1'b0;
    end else if (frm_start) begin
      if ((state_q == HB_WAIT) && !coll_in) fail_d = 1'b1;
      state_d = HB_TX;
      seen_d  = 1'b0;
      tmr_d   = '0;
    end else begin
      unique case (state_q)
        HB_TX: begin
          if (coll_in) seen_d = 1'b1;
          if (frm_end) begin
            tmr_d   = '0;
            state_d = (seen_q || coll_in) ? HB_IDLE : HB_WAIT;
            seen_d  = 1'b0;
          end
        end
        HB_WAIT: begin
          if (coll_in) begin
            state_d = HB_IDLE;
          end else if (tmr_q == TLAST) begin
            state_d = HB_IDLE;
            fail_d  = 1'b1;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
        default: state_d = HB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HB_IDLE;
      tmr_q   <= '0;
      seen_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      seen_q  <= seen_d;
      fail_q  <= fail_d;
    end
  end

  assign hb_fail_pulse = fail_q;

  assert_tmr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q < TW'(WIN));
  assert_coll_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HB_WAIT && coll_in) |=> !hb_fail_pulse);
  assert_abort_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_abort |=> !hb_fail_pulse);
  assert_start_resolves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HB_WAIT && frm_start && !coll_in && !frm_abort) |=> hb_fail_pulse);
  assert_fail_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hb_fail_pulse |=> !hb_fail_pulse);
  assert_seen_no_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HB_TX && seen_q && frm_end && !frm_start && !frm_abort) |=> !hb_fail_pulse);
endmodule

// File: rtl/txm_monitor.sv
module txm_monitor #(
  parameter int unsigned BABBLE_BYTES = 1519,
  parameter int unsigned CYC_PER_US   = 10,
  parameter int unsigned WIN_US       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic frm_end,
  input  logic frm_abort,
  input  logic byte_vld,
  input  logic coll_in,
  output logic babble_pulse,
  output logic hb_fail_pulse
);
  localparam int unsigned WIN = WIN_US * CYC_PER_US;

  logic frm_stop;
  assign frm_stop = frm_end | frm_abort;

  txm_len_guard #(.LIMIT(BABBLE_BYTES)) u_len (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_start    (frm_start),
    .frm_stop     (frm_stop),
    .byte_vld     (byte_vld),
    .babble_pulse (babble_pulse)
  );

  txm_sqe_watch #(.WIN(WIN)) u_sqe (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_start     (frm_start),
    .frm_end       (frm_end),
    .frm_abort     (frm_abort),
    .coll_in       (coll_in),
    .hb_fail_pulse (hb_fail_pulse)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!babble_pulse && !hb_fail_pulse));
endmodule

// File: tb/sim_txm_monitor.sv
module sim_txm_monitor;
  localparam int PERIOD = 10;
  localparam int LIM    = 1519;
  localparam int WIN    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 1'b0, frm_end = 1'b0, frm_abort = 1'b0;
  logic byte_vld = 1'b0, coll_in = 1'b0;
  logic babble_pulse, hb_fail_pulse;

  int n_chk = 0;
  int n_fail = 0;
  int nb = 0;
  int nh = 0;
  bit done = 1'b0;

  txm_monitor u0 (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .frm_abort(frm_abort), .byte_vld(byte_vld), .coll_in(coll_in),
    .babble_pulse(babble_pulse), .hb_fail_pulse(hb_fail_pulse)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (babble_pulse) nb++;
    if (hb_fail_pulse) nh++;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_babble(input int nbytes);
    return (nbytes >= LIM) ? 1 : 0;
  endfunction

  // mode 0: no collision, 1: inside frame, 2: dly cycles after end
  function automatic int exp_hb(input int mode, input int dly, input bit abrt);
    if (abrt) return 0;
    if (mode == 1) return 0;
    if (mode == 2 && dly < WIN) return 0;
    return 1;
  endfunction

  task automatic run_frame(input int nbytes, input int mode, input int dly,
                           input bit abrt, input string tag);
    nb = 0; nh = 0;
    frm_start = 1'b1; tick(); frm_start = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      byte_vld = 1'b1;
      coll_in  = (mode == 1) && (i == nbytes / 2);
      tick();
      if (i == LIM - 1)
        chk(babble_pulse == 1'b1, {tag, " R2 pulse timing"}, babble_pulse, 1);
    end
    byte_vld = 1'b0; coll_in = 1'b0;
    if (abrt) frm_abort = 1'b1; else frm_end = 1'b1;
    tick();
    frm_abort = 1'b0; frm_end = 1'b0;
    for (int k = 0; k < WIN + 3; k++) begin
      coll_in = (mode == 2) && (k == dly);
      tick();
      if (!abrt && mode == 0 && k == WIN - 2)
        chk(hb_fail_pulse == 1'b0, {tag, " R8 no early fail"}, hb_fail_pulse, 0);
      if (!abrt && mode == 0 && k == WIN - 1)
        chk(hb_fail_pulse == 1'b1, {tag, " R7 fail at window end"}, hb_fail_pulse, 1);
    end
    coll_in = 1'b0;
    tick();
    chk(nb == exp_babble(nbytes), {tag, " R4 babble count"}, nb, exp_babble(nbytes));
    chk(nh == exp_hb(mode, dly, abrt), {tag, " R6/R7/R10 heartbeat count"}, nh, exp_hb(mode, dly, abrt));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) tick();
    chk(babble_pulse == 1'b0 && hb_fail_pulse == 1'b0, "R1 reset outputs", babble_pulse + hb_fail_pulse, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(babble_pulse == 1'b0 && hb_fail_pulse == 1'b0, "R1 after release", babble_pulse + hb_fail_pulse, 0);

    run_frame(LIM - 1, 1, 0, 1'b0, "R3 1518 bytes");
    run_frame(LIM, 1, 0, 1'b0, "R2 1519 bytes");
    run_frame(1600, 1, 0, 1'b0, "R4 long frame");
    run_frame(1600, 1, 0, 1'b0, "R4 second long frame");
    run_frame(20, 0, 0, 1'b0, "R7 no collision");
    run_frame(20, 2, 0, 1'b0, "R7 first window cycle");
    run_frame(20, 2, WIN - 1, 1'b0, "R8 last window cycle");
    run_frame(20, 2, WIN, 1'b0, "R8 one past window");
    run_frame(20, 0, 0, 1'b1, "R10 abort");

    // R5: stray bytes after a 1518-byte frame must not complete a babble
    run_frame(LIM - 1, 1, 0, 1'b0, "R5 base frame");
    nb = 0;
    byte_vld = 1'b1;
    repeat (10) tick();
    byte_vld = 1'b0;
    tick();
    chk(nb == 0, "R5 stray bytes ignored", nb, 0);

    // R9: new frame opens while window is pending
    frm_start = 1'b1; tick(); frm_start = 1'b0;
    frm_end = 1'b1; tick(); frm_end = 1'b0;
    repeat (5) tick();
    nh = 0;
    frm_start = 1'b1; tick(); frm_start = 1'b0;
    chk(hb_fail_pulse == 1'b1, "R9 resolve on restart", hb_fail_pulse, 1);
    tick();
    chk(hb_fail_pulse == 1'b0, "R11 single-cycle fail", hb_fail_pulse, 0);
    coll_in = 1'b1; tick(); coll_in = 1'b0;
    frm_end = 1'b1; tick(); frm_end = 1'b0;
    repeat (WIN + 3) tick();
    chk(nh == 1, "R9 only one failure", nh, 1);

    for (int r = 0; r < 12; r++) begin
      int n, m, d;
      bit a;
      n = 1510 + int'($urandom_range(0, 25));
      m = int'($urandom_range(0, 2));
      d = int'($urandom_range(0, WIN + 2));
      a = ($urandom_range(0, 7) == 0);
      run_frame(n, m, d, a, "R2/R6 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule